// File: doc/BRIEF.md
# TDMA Scheduler Control Register Block

This block is the software-facing register file of a time-division scheduler. A simple 32-bit read/write port, with one-cycle write and read strobes, reaches a small fixed header: a type word, a version word, a pointer to the next register block and the number of supported timeslots. It also holds an enable control bit and a status word that mirrors the core's lock and error flags. Four multi-word time values sit behind the same port: schedule start, schedule period, timeslot period and active period.

Each time value is 128 bits wide and is written as four 32-bit words. The three lower words go into staging registers only. Writing the most significant seconds word copies all four staged words into the committed value that the scheduler core sees, and raises a one-cycle update strobe for that value. The core therefore never sees a half-written time. Reads of the time words return the staged contents.

Top module: `tdma_csr`

## Requirements
- R1: Reads at byte offsets 0x00, 0x04, 0x08 and 0x0C return the parameters TYPE_ID (default 0x0000C060), VERSION_ID (default 0x00000100), NEXT_PTR and SLOT_COUNT. Read data appears on `rdata` on the clock edge that samples `rd_en` and holds until the next read.
- R2: Bit 0 of the control word at 0x10 drives `sched_en`. The other bits read as zero, and `sched_en` changes only after a write to 0x10.
- R3: A read of 0x14 returns `error` in bit 1, `locked` in bit 0 and zero in the other bits.
- R4: A write to word 0, 1 or 2 of a time value changes only its staging register. The committed output stays unchanged and no update strobe rises. A read returns the staged word.
- R5: A time value has words at base+0x0 (fractional ns), +0x4 (ns), +0x8 (seconds low) and +0xC (seconds high). The bases are 0x20 for schedule start, 0x30 for schedule period, 0x40 for timeslot period and 0x50 for active period. A write to +0xC sets the 128-bit output to {seconds high, seconds low, ns, fractional ns} on that edge, using the staged lower words.
- R6: `upd` bit k (0 start, 1 schedule period, 2 timeslot period, 3 active period) is high for exactly the cycle after a committing write to value k. At most one bit is set.
- R7: Reads of unmapped offsets (0x18, 0x1C, 0x60 and above) and of addresses that are not word aligned return zero. Writes to read-only, unmapped or misaligned addresses change nothing.
- R8: After reset the control bit, all staged and committed values, `upd` and `rdata` are zero.
- R9: Committing one time value leaves the other three committed values unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| addr | input | ADDR_W | Byte address of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| locked | input | 1 | Lock flag from the scheduler core |
| error | input | 1 | Error flag from the scheduler core |
| sched_en | output | 1 | Scheduler enable |
| start_time | output | 128 | Committed schedule start time |
| sched_period | output | 128 | Committed schedule period |
| slot_period | output | 128 | Committed timeslot period |
| active_period | output | 128 | Committed active period |
| upd | output | 4 | One-cycle commit strobes, one per time value |

## Verification
The bench writes the three lower words of each time value and confirms that neither the committed output nor the strobes move. A design that committed on every word would show a torn value here. It then commits the value and checks the full 128-bit word ordering, the single strobe bit, and that the other three values are unchanged. A design that decoded the wrong base, or lost the staged lower words, fails these checks. A second commit that writes only the seconds-high word must reuse the previously staged lower words. Misaligned, unmapped and read-only accesses are exercised so that a loose address decode shows up as a spurious read value or an unexpected strobe.

// File: rtl/tdma_csr.sv
module tdma_csr #(
  parameter int          ADDR_W     = 8,
  parameter logic [31:0] TYPE_ID    = 32'h0000_C060,
  parameter logic [31:0] VERSION_ID = 32'h0000_0100,
  parameter logic [31:0] NEXT_PTR   = 32'h0000_0000,
  parameter logic [31:0] SLOT_COUNT = 32'd8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              locked,
  input  logic              error,
  output logic              sched_en,
  output logic [127:0]      start_time,
  output logic [127:0]      sched_period,
  output logic [127:0]      slot_period,
  output logic [127:0]      active_period,
  output logic [3:0]        upd
);

  localparam int NVAL = 4;
  localparam int NWRD = 4;

  logic [NWRD-1:0][31:0] stg  [NVAL];
  logic [127:0]          live [NVAL];
  logic                  ctl_en;
  logic [31:0]           rd_mux;

  wire       hit    = ((addr >> 8) == '0) && (addr[1:0] == 2'b00);
  wire [5:0] word   = addr[7:2];
  wire       in_tv  = hit && (word >= 6'd8) && (word < 6'd24);
  wire [1:0] tv_idx = word[3:2] - 2'd2;
  wire [1:0] tv_wrd = word[1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_en <= 1'b0;
      upd    <= '0;
      for (int v = 0; v < NVAL; v++) begin
        stg[v]  <= '0;
        live[v] <= '0;
      end
    end else begin
      upd <= '0;
      if (wr_en && hit && word == 6'd4)
        ctl_en <= wdata[0];
      if (wr_en && in_tv) begin
        stg[tv_idx][tv_wrd] <= wdata;
        if (tv_wrd == 2'd3) begin
          live[tv_idx] <= {wdata, stg[tv_idx][2], stg[tv_idx][1], stg[tv_idx][0]};
          upd[tv_idx]  <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (hit) begin
      if (in_tv)
        rd_mux = stg[tv_idx][tv_wrd];
      else
        case (word)
          6'd0:    rd_mux = TYPE_ID;
          6'd1:    rd_mux = VERSION_ID;
          6'd2:    rd_mux = NEXT_PTR;
          6'd3:    rd_mux = SLOT_COUNT;
          6'd4:    rd_mux = {31'd0, ctl_en};
          6'd5:    rd_mux = {30'd0, error, locked};
          default: rd_mux = '0;
        endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      rdata <= '0;
    else if (rd_en)
      rdata <= rd_mux;
  end

  assign sched_en      = ctl_en;
  assign start_time    = live[0];
  assign sched_period  = live[1];
  assign slot_period   = live[2];
  assign active_period = live[3];

endmodule

// File: rtl/tdma_csr_chk.sv
module tdma_csr_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       rdata,
  input logic              sched_en,
  input logic [127:0]      start_time,
  input logic [127:0]      sched_period,
  input logic [127:0]      slot_period,
  input logic [127:0]      active_period,
  input logic [3:0]        upd
);

  wire       aligned = ((addr >> 8) == '0) && (addr[1:0] == 2'b00);
  wire [5:0] w       = addr[7:2];
  wire       commit  = wr_en && aligned && w >= 6'd8 && w < 6'd24 && w[1:0] == 2'd3;
  wire       unmap   = !aligned || w == 6'd6 || w == 6'd7 || w >= 6'd24;
  wire       ctl_wr  = wr_en && aligned && w == 6'd4;

  p_upd_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(upd));

  p_upd_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (upd != 4'd0) |-> $past(commit));

  p_start_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !upd[0] |-> $stable(start_time));

  p_sper_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !upd[1] |-> $stable(sched_period));

  p_tper_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !upd[2] |-> $stable(slot_period));

  p_aper_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !upd[3] |-> $stable(active_period));

  p_en_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ctl_wr) |-> $stable(sched_en));

  p_unmapped_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_en && unmap) |-> rdata == 32'd0);

endmodule

bind tdma_csr tdma_csr_chk #(.ADDR_W(ADDR_W)) i_tdma_csr_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .rdata(rdata), .sched_en(sched_en), .start_time(start_time),
  .sched_period(sched_period), .slot_period(slot_period),
  .active_period(active_period), .upd(upd)
);

// File: tb/test_tdma_csr.sv
module test_tdma_csr;
  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] NPTR       = 32'h0000_0400;
  localparam logic [31:0] NSLOT      = 32'd16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]   addr = '0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic         locked = 1'b0, error = 1'b0;
  logic         sched_en;
  logic [127:0] start_time, sched_period, slot_period, active_period;
  logic [3:0]   upd;

  int checks = 0;
  int fails  = 0;

  logic [31:0]  exp_q[$];
  string        tag_q[$];
  logic [127:0] mdl_live [4];
  logic [31:0]  mdl_stg  [4][4];

  always #(CLK_PERIOD/2) clk = ~clk;

  tdma_csr #(.ADDR_W(8), .NEXT_PTR(NPTR), .SLOT_COUNT(NSLOT)) i_tdma_csr (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .locked(locked), .error(error),
    .sched_en(sched_en), .start_time(start_time), .sched_period(sched_period),
    .slot_period(slot_period), .active_period(active_period), .upd(upd)
  );

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] tv(input int p);
    case (p)
      0:       tv = start_time;
      1:       tv = sched_period;
      2:       tv = slot_period;
      default: tv = active_period;
    endcase
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  always @(posedge clk) begin
    if (rd_en) begin
      #1;
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL scoreboard read with no expected item");
      end else
        check(tag_q.pop_front(), {96'd0, rdata}, {96'd0, exp_q.pop_front()});
    end
  end

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    for (int p = 0; p < 4; p++) begin
      mdl_live[p] = '0;
      for (int w = 0; w < 4; w++) mdl_stg[p][w] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    check("R8 enable", {127'd0, sched_en}, 128'd0);
    check("R8 strobes", {124'd0, upd}, 128'd0);
    check("R8 rdata", {96'd0, rdata}, 128'd0);
    for (int p = 0; p < 4; p++) check("R8 committed", tv(p), 128'd0);
    rd(8'h24, 32'd0, "R8 staged zero");

    rd(8'h00, 32'h0000_C060, "R1 type");
    rd(8'h04, 32'h0000_0100, "R1 version");
    rd(8'h08, NPTR, "R1 next pointer");
    rd(8'h0C, NSLOT, "R1 slot count");

    wr(8'h00, 32'hDEAD_BEEF);
    wr(8'h0C, 32'h1234_5678);
    rd(8'h00, 32'h0000_C060, "R7 type write ignored");
    rd(8'h0C, NSLOT, "R7 count write ignored");
    rd(8'h18, 32'd0, "R7 unmapped 0x18");
    rd(8'h1C, 32'd0, "R7 unmapped 0x1C");
    rd(8'h60, 32'd0, "R7 unmapped 0x60");
    rd(8'hFC, 32'd0, "R7 unmapped 0xFC");
    rd(8'h01, 32'd0, "R7 misaligned read");

    wr(8'h10, 32'hFFFF_FFFF);
    check("R2 enable set", {127'd0, sched_en}, 128'd1);
    rd(8'h10, 32'd1, "R2 control readback");
    wr(8'h11, 32'h0000_0000);
    check("R7 misaligned control write", {127'd0, sched_en}, 128'd1);
    wr(8'h10, 32'hFFFF_FFFE);
    check("R2 enable clear", {127'd0, sched_en}, 128'd0);

    locked = 1'b1; error = 1'b0;
    rd(8'h14, 32'd1, "R3 locked");
    locked = 1'b1; error = 1'b1;
    rd(8'h14, 32'd3, "R3 locked and error");
    wr(8'h14, 32'd0);
    locked = 1'b0; error = 1'b1;
    rd(8'h14, 32'd2, "R3 error only");

    for (int p = 0; p < 4; p++) begin
      logic [7:0] base;
      base = 8'h20 + 8'(p * 16);
      for (int w = 0; w < 3; w++) begin
        mdl_stg[p][w] = 32'hA000_0000 + 32'(p << 16) + 32'(w * 32'h111);
        wr(base + 8'(w * 4), mdl_stg[p][w]);
        check("R4 no strobe on lower word", {124'd0, upd}, 128'd0);
        check("R4 committed unchanged", tv(p), mdl_live[p]);
      end
      for (int w = 0; w < 3; w++) rd(base + 8'(w * 4), mdl_stg[p][w], "R4 staged readback");
      mdl_stg[p][3] = 32'h5000_0000 + 32'(p);
      wr(base + 8'hC, mdl_stg[p][3]);
      mdl_live[p] = {mdl_stg[p][3], mdl_stg[p][2], mdl_stg[p][1], mdl_stg[p][0]};
      check("R6 strobe bit", {124'd0, upd}, 128'(1 << p));
      check("R5 committed value", tv(p), mdl_live[p]);
      for (int q = 0; q < 4; q++)
        if (q != p) check("R9 other values untouched", tv(q), mdl_live[q]);
      @(negedge clk);
      check("R6 strobe one cycle", {124'd0, upd}, 128'd0);
    end

    wr(8'h2C, 32'h7777_0001);
    mdl_live[0] = {32'h7777_0001, mdl_stg[0][2], mdl_stg[0][1], mdl_stg[0][0]};
    check("R5 recommit reuses staged words", start_time, mdl_live[0]);
    check("R6 recommit strobe", {124'd0, upd}, 128'd1);
    rd(8'h2C, 32'h7777_0001, "R4 high word readback");

    wr(8'h3D, 32'hFFFF_FFFF);
    check("R7 misaligned commit ignored", {124'd0, upd}, 128'd0);
    check("R7 period unchanged", sched_period, mdl_live[1]);
    rd(8'h3C, mdl_stg[1][3], "R7 staged unchanged");

    wait (exp_q.size() == 0);
    repeat (2) @(negedge clk);
    summary();
  end
endmodule